// File: doc/BRIEF.md
# Bounded Downward Stack Controller

This block keeps a last-in, first-out stack in an external synchronous memory. Its stack pointer moves toward lower addresses. A push lowers the pointer by one and then writes the incoming word at the new top address. A pop reads the word at the current top address and then raises the pointer by one. Two parameters fix the address window. The upper address is the deepest slot. The lower address is the last slot that can be filled. The pointer rests one above the upper address when the stack holds nothing.

Before each request changes anything, the controller tests it against the bounds. A request is refused in three cases: a push into a full stack, a pop from an empty stack, or a push and pop raised together. A refused request leaves the pointer and the memory untouched. Every request ends with a one-cycle completion pulse and a status bit, where 0 means success and 1 means refusal. Data returned by a pop stays on the output until the next successful pop. A host drives one request at a time while the controller is idle. The memory has a fixed, parameterised read latency.

Top module: `lifo_down_ctrl`

## Requirements
- R1: After reset the pointer is one above `BASE_ADDR` (empty stack), `req_rdy` is 1, `rsp_done` and `rsp_fail` are 0 and `rsp_data` is 0.
- R2: An accepted push performs exactly one memory write, at address (pointer − 1), with the request word; with k items stored the write address is `BASE_ADDR` − k.
- R3: An accepted pop performs exactly one memory read at the current pointer, `BASE_ADDR` − k + 1 with k items stored, returns that word on `rsp_data`, and then raises the pointer by one.
- R4: A push when the pointer equals `LIMIT_ADDR` (k = `BASE_ADDR` − `LIMIT_ADDR` + 1 items) is refused: `rsp_fail` = 1 and no memory write occurs.
- R5: A pop when the stack is empty is refused: `rsp_fail` = 1 and no memory read occurs.
- R6: Every request sampled while `req_rdy` is 1 yields exactly one cycle of `rsp_done`. `rsp_fail` is high only together with `rsp_done`, and it is 0 for a successful operation.
- R7: A push and a pop raised in the same cycle are refused with `rsp_fail` = 1, with no memory access and no pointer change.
- R8: `req_rdy` is 0 while an operation is in progress, and requests presented then are ignored.
- R9: `rsp_data` changes only in the cycle in which a successful pop completes.
- R10: Successful pops return words in the reverse order of the successful pushes.
- R11: Counting from the clock edge that samples a request, `rsp_done` is high after that edge for a refused request, after the next edge for a push, and after 1 + `RD_LAT` further edges for a pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_push | input | 1 | Push request, sampled while `req_rdy` is 1 |
| req_pop | input | 1 | Pop request, sampled while `req_rdy` is 1 |
| req_data | input | DATA_W | Word to push |
| req_rdy | output | 1 | Controller idle and able to take a request |
| rsp_data | output | DATA_W | Last word returned by a successful pop |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fail | output | 1 | Refusal status, valid with `rsp_done` |
| mem_addr | output | ADDR_W | Memory address (the stack pointer) |
| mem_wen | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ren | output | 1 | Memory read strobe |
| mem_rdata | input | DATA_W | Memory read data, valid `RD_LAT` cycles after `mem_ren` |

## Verification
The bench fills the stack to its lower limit and pushes once more. A pointer test that is off by one shows up here as a write outside the window or as a refusal one slot early. It also drains the stack and pops once more. A design that skips the empty test then issues a read above the base and returns stale data. Simultaneous push and pop requests and requests presented mid-operation are also exercised. A design that lets these through changes the pointer, so later pops come back out of order or from the wrong address. Random traffic with pops interleaved with pushes checks that `rsp_data` holds between pops and that each completion pulse arrives on its expected cycle.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_READ  = 2'd2,
      ST_WAIT  = 2'd3
   } lifo_state_e;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_PUSH  = 2'd1,
      OP_POP   = 2'd2,
      OP_CLASH = 2'd3
   } lifo_op_e;

   function automatic lifo_op_e decode_op(input logic push, input logic pop);
      lifo_op_e op;
      case ({push, pop})
         2'b10:   op = OP_PUSH;
         2'b01:   op = OP_POP;
         2'b11:   op = OP_CLASH;
         default: op = OP_NONE;
      endcase
      return op;
   endfunction

endpackage

// File: rtl/lifo_sp.sv
module lifo_sp #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned EMPTY_VAL = 'h4000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sp_dec,
   input  logic              sp_inc,
   output logic [ADDR_W-1:0] sp
);

   localparam logic [ADDR_W-1:0] RESET_SP = ADDR_W'(EMPTY_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp <= RESET_SP;
      end else if (sp_dec) begin
         sp <= sp - 1'b1;
      end else if (sp_inc) begin
         sp <= sp + 1'b1;
      end
   end

endmodule

// File: rtl/lifo_bounds.sv
module lifo_bounds #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned BASE_ADDR  = 'h3FFF,
   parameter int unsigned LIMIT_ADDR = 'h3FFB
) (
   input  logic [ADDR_W-1:0] sp,
   output logic              full,
   output logic              empty
);

   localparam int unsigned       CAPACITY  = BASE_ADDR - LIMIT_ADDR + 1;
   localparam logic [ADDR_W-1:0] LIMIT_PTR = ADDR_W'(LIMIT_ADDR);
   localparam logic [ADDR_W-1:0] EMPTY_PTR = ADDR_W'(BASE_ADDR + 1);

   assign empty = (sp == EMPTY_PTR);

   generate
      if (CAPACITY == 1) begin : g_single
         // one slot: anything other than empty is full
         assign full = !empty;
      end else begin : g_multi
         assign full = (sp == LIMIT_PTR);
      end
   endgenerate

endmodule

// File: rtl/lifo_seq.sv
module lifo_seq
   import lifo_pkg::*;
#(
   parameter int unsigned RD_LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_push,
   input  logic req_pop,
   input  logic full,
   input  logic empty,
   output logic ready,
   output logic sp_dec,
   output logic sp_inc,
   output logic wdata_load,
   output logic rdata_take,
   output logic mem_wen,
   output logic mem_ren,
   output logic done,
   output logic fail
);

   localparam int unsigned CNT_W = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;

   lifo_state_e state_q, state_d;
   logic        done_d, fail_d;
   logic        wait_last;
   lifo_op_e    op;

   assign op = decode_op(req_push, req_pop);

   generate
      if (RD_LAT == 1) begin : g_lat1
         assign wait_last = 1'b1;
      end else begin : g_latn
         logic [CNT_W-1:0] wait_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wait_cnt <= '0;
            end else if (state_q == ST_READ) begin
               wait_cnt <= CNT_W'(RD_LAT - 1);
            end else if (state_q == ST_WAIT && wait_cnt != '0) begin
               wait_cnt <= wait_cnt - 1'b1;
            end
         end
         assign wait_last = (wait_cnt == '0);
      end
   endgenerate

   always_comb begin
      state_d    = state_q;
      done_d     = 1'b0;
      fail_d     = 1'b0;
      sp_dec     = 1'b0;
      sp_inc     = 1'b0;
      wdata_load = 1'b0;
      rdata_take = 1'b0;
      mem_wen    = 1'b0;
      mem_ren    = 1'b0;
      ready      = 1'b0;
      case (state_q)
         ST_IDLE: begin
            ready = 1'b1;
            case (op)
               OP_CLASH: begin
                  done_d = 1'b1;
                  fail_d = 1'b1;
               end
               OP_PUSH: begin
                  if (full) begin
                     done_d = 1'b1;
                     fail_d = 1'b1;
                  end else begin
                     sp_dec     = 1'b1;
                     wdata_load = 1'b1;
                     state_d    = ST_WRITE;
                  end
               end
               OP_POP: begin
                  if (empty) begin
                     done_d = 1'b1;
                     fail_d = 1'b1;
                  end else begin
                     state_d = ST_READ;
                  end
               end
               default: ;
            endcase
         end
         ST_WRITE: begin
            mem_wen = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
         end
         ST_READ: begin
            mem_ren = 1'b1;
            state_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (wait_last) begin
               rdata_take = 1'b1;
               sp_inc     = 1'b1;
               done_d     = 1'b1;
               state_d    = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done    <= 1'b0;
         fail    <= 1'b0;
      end else begin
         state_q <= state_d;
         done    <= done_d;
         fail    <= fail_d;
      end
   end

endmodule

// File: rtl/lifo_down_ctrl.sv
module lifo_down_ctrl #(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned BASE_ADDR  = 'h3FFF,
   parameter int unsigned LIMIT_ADDR = 'h3FFB,
   parameter int unsigned RD_LAT     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_push,
   input  logic              req_pop,
   input  logic [DATA_W-1:0] req_data,
   output logic              req_rdy,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_done,
   output logic              rsp_fail,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_wen,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_ren,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int unsigned EMPTY_VAL = BASE_ADDR + 1;

   generate
      if (DATA_W < 1) begin : g_bad_dw
         $error("lifo_down_ctrl: DATA_W must be at least 1");
      end
      if (RD_LAT < 1) begin : g_bad_lat
         $error("lifo_down_ctrl: RD_LAT must be at least 1");
      end
      if (LIMIT_ADDR > BASE_ADDR) begin : g_bad_win
         $error("lifo_down_ctrl: LIMIT_ADDR must not exceed BASE_ADDR");
      end
      if (ADDR_W < 32 && EMPTY_VAL >= (64'd1 << ADDR_W)) begin : g_bad_aw
         $error("lifo_down_ctrl: BASE_ADDR + 1 must fit in ADDR_W bits");
      end
   endgenerate

   logic              full, empty;
   logic              sp_dec, sp_inc, wdata_load, rdata_take;
   logic [ADDR_W-1:0] sp;
   logic [DATA_W-1:0] wdata_q, rdata_q;

   lifo_sp #(
      .ADDR_W   (ADDR_W),
      .EMPTY_VAL(EMPTY_VAL)
   ) i_sp (
      .clk   (clk),
      .rst_n (rst_n),
      .sp_dec(sp_dec),
      .sp_inc(sp_inc),
      .sp    (sp)
   );

   lifo_bounds #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .LIMIT_ADDR(LIMIT_ADDR)
   ) i_bounds (
      .sp   (sp),
      .full (full),
      .empty(empty)
   );

   lifo_seq #(
      .RD_LAT(RD_LAT)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_push  (req_push),
      .req_pop   (req_pop),
      .full      (full),
      .empty     (empty),
      .ready     (req_rdy),
      .sp_dec    (sp_dec),
      .sp_inc    (sp_inc),
      .wdata_load(wdata_load),
      .rdata_take(rdata_take),
      .mem_wen   (mem_wen),
      .mem_ren   (mem_ren),
      .done      (rsp_done),
      .fail      (rsp_fail)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         if (wdata_load) wdata_q <= req_data;
         if (rdata_take) rdata_q <= mem_rdata;
      end
   end

   assign mem_addr  = sp;
   assign mem_wdata = wdata_q;
   assign rsp_data  = rdata_q;

endmodule

// File: rtl/lifo_down_ctrl_chk.sv
module lifo_down_ctrl_chk #(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned BASE_ADDR  = 'h3FFF,
   parameter int unsigned LIMIT_ADDR = 'h3FFB
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_rdy,
   input logic [DATA_W-1:0] rsp_data,
   input logic              rsp_done,
   input logic              rsp_fail,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_wen,
   input logic              mem_ren
);

   localparam logic [ADDR_W-1:0] LO = ADDR_W'(LIMIT_ADDR);
   localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE_ADDR);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wen |-> (mem_addr >= LO && mem_addr <= HI)); // R4
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ren |-> (mem_addr >= LO && mem_addr <= HI)); // R5
   AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wen && mem_ren)); // R2
   AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fail |-> rsp_done); // R6
   AST_BUSY_DURING_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wen || mem_ren) |-> !req_rdy); // R8
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rsp_data) |-> (rsp_done && !rsp_fail)); // R9

endmodule

bind lifo_down_ctrl lifo_down_ctrl_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .BASE_ADDR (BASE_ADDR),
   .LIMIT_ADDR(LIMIT_ADDR)
) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .req_rdy (req_rdy),
   .rsp_data(rsp_data),
   .rsp_done(rsp_done),
   .rsp_fail(rsp_fail),
   .mem_addr(mem_addr),
   .mem_wen (mem_wen),
   .mem_ren (mem_ren)
);

// File: tb/test_lifo_down_ctrl.sv
module test_lifo_down_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int DW    = 16;
   localparam int AW    = 16;
   localparam int BASE  = 'h3FFF;
   localparam int LIMIT = 'h3FFB;
   localparam int LAT   = 1;
   localparam int CAP   = BASE - LIMIT + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_push = 1'b0, req_pop = 1'b0;
   logic [DW-1:0] req_data = '0;
   logic          req_rdy, rsp_done, rsp_fail, mem_wen, mem_ren;
   logic [DW-1:0] rsp_data, mem_wdata, mem_rdata;
   logic [AW-1:0] mem_addr;

   int checks = 0, fails = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lifo_down_ctrl #(
      .DATA_W(DW), .ADDR_W(AW), .BASE_ADDR(BASE), .LIMIT_ADDR(LIMIT), .RD_LAT(LAT)
   ) i_lifo_down_ctrl (
      .clk(clk), .rst_n(rst_n), .req_push(req_push), .req_pop(req_pop),
      .req_data(req_data), .req_rdy(req_rdy), .rsp_data(rsp_data),
      .rsp_done(rsp_done), .rsp_fail(rsp_fail), .mem_addr(mem_addr),
      .mem_wen(mem_wen), .mem_wdata(mem_wdata), .mem_ren(mem_ren),
      .mem_rdata(mem_rdata)
   );

   // memory model with LAT = 1 read latency
   logic [DW-1:0] ram [CAP];
   int wr_cnt = 0, rd_cnt = 0, oor_cnt = 0;
   logic [AW-1:0] last_waddr = '0, last_raddr = '0;
   logic [DW-1:0] last_wdata = '0;
   logic          addr_ok;
   int            addr_idx;
   assign addr_ok  = (int'(mem_addr) >= LIMIT) && (int'(mem_addr) <= BASE);
   assign addr_idx = addr_ok ? int'(mem_addr) - LIMIT : 0;

   always_ff @(posedge clk) begin
      if (mem_wen) begin
         wr_cnt     <= wr_cnt + 1;
         last_waddr <= mem_addr;
         last_wdata <= mem_wdata;
         if (addr_ok) ram[addr_idx] <= mem_wdata;
         else oor_cnt <= oor_cnt + 1;
      end
      if (mem_ren) begin
         rd_cnt     <= rd_cnt + 1;
         last_raddr <= mem_addr;
         if (addr_ok) mem_rdata <= ram[addr_idx];
         else begin
            mem_rdata <= 'x;
            oor_cnt   <= oor_cnt + 1;
         end
      end
   end

   // reference model
   logic [DW-1:0] mdl [CAP];
   int            depth = 0;
   logic [DW-1:0] exp_dout = '0;

   function automatic int exp_push_addr(input int k); return BASE - k; endfunction
   function automatic int exp_pop_addr(input int k);  return BASE - k + 1; endfunction
   function automatic bit exp_refuse(input bit p, input bit q, input int k);
      return (p && q) || (p && k == CAP) || (q && k == 0);
   endfunction
   function automatic int exp_latency(input bit p, input bit q, input int k);
      if (exp_refuse(p, q, k)) return 1;
      return p ? 2 : 2 + LAT;
   endfunction

   task automatic check(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_op(input bit p, input bit q, input logic [DW-1:0] d, input bit inject);
      int  wr0 = wr_cnt, rd0 = rd_cnt;
      bit  refuse = exp_refuse(p, q, depth);
      int  lat = exp_latency(p, q, depth);
      int  first = 0, hits = 0;
      bit  got_fail = 1'b0;
      @(negedge clk);
      req_push = p; req_pop = q; req_data = d;
      for (int n = 1; n <= 5; n++) begin
         @(negedge clk);
         if (rsp_done) begin
            hits++;
            if (first == 0) begin first = n; got_fail = rsp_fail; end
         end
         if (n == 1) begin
            if (!refuse) begin
               check("R8 busy after accept", req_rdy, 0);
               if (inject) begin req_push = q; req_pop = p; req_data = ~d; end
               else begin req_push = 0; req_pop = 0; end
            end else begin
               req_push = 0; req_pop = 0;
            end
         end else if (n == 2) begin
            req_push = 0; req_pop = 0;
         end
      end
      check("R6 single done pulse", hits, 1);
      check("R11 done latency", first, lat);
      if (p && q) check("R7 clash refused", got_fail, 1);
      else if (p && refuse) check("R4 full push refused", got_fail, 1);
      else if (q && refuse) check("R5 empty pop refused", got_fail, 1);
      else check("R6 success status", got_fail, 0);
      if (refuse) begin
         check("R4 R5 R7 no write on refusal", wr_cnt - wr0, 0);
         check("R5 R7 no read on refusal", rd_cnt - rd0, 0);
      end else if (p) begin
         check("R2 one write", wr_cnt - wr0, 1);
         check("R2 write address", last_waddr, exp_push_addr(depth));
         check("R2 write data", last_wdata, d);
         check("R8 no read on push", rd_cnt - rd0, 0);
         mdl[depth] = d;
         depth++;
      end else begin
         check("R3 one read", rd_cnt - rd0, 1);
         check("R3 read address", last_raddr, exp_pop_addr(depth));
         check("R8 no write on pop", wr_cnt - wr0, 0);
         depth--;
         exp_dout = mdl[depth];
      end
      check("R3 R9 R10 popped data", rsp_data, exp_dout);
      check("R4 R5 no stray address", oor_cnt, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 ready in reset", req_rdy, 1);
      check("R1 done in reset", rsp_done, 0);
      check("R1 fail in reset", rsp_fail, 0);
      check("R1 data in reset", rsp_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", req_rdy, 1);
      // R1 R5: stack starts empty
      run_op(0, 1, 16'h0000, 0);
      // R2 R4: fill to the limit, then overflow
      for (int i = 0; i < CAP; i++) run_op(1, 0, 16'hA000 + 16'(i), i[0]);
      run_op(1, 0, 16'hDEAD, 0);
      // R7: clash leaves state alone
      run_op(1, 1, 16'hBEEF, 0);
      // R3 R10: drain in reverse order, then underflow
      for (int i = 0; i < CAP; i++) run_op(0, 1, 16'h0000, i[0]);
      run_op(0, 1, 16'h0000, 0);
      run_op(1, 1, 16'h1234, 0);
      // random traffic
      for (int i = 0; i < 400; i++) begin
         int r = int'($urandom % 10);
         logic [DW-1:0] d = DW'($urandom);
         bit inj = ($urandom % 3) == 0;
         if (r < 5)      run_op(1, 0, d, inj);
         else if (r < 9) run_op(0, 1, d, inj);
         else            run_op(1, 1, d, 0);
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule